// File: doc/BRIEF.md
# USB Receive Bit Step Unit

This unit handles one received bit of a low- or full-speed USB line each time it is asked to. Software or a sequencer samples the differential pair once per bit time and raises `step` with the two line levels. The unit then does the whole per-bit job in that one step. It decodes the NRZI line level against the level of the previous bit and drops the bit that the sender stuffed after a run of ones. It shifts the decoded bit into an assembling byte and folds it into a running CRC.

Two flags come back with the byte. `z_o` says the step just finished a byte. `c_o` says the pair was sampled in a single-ended state (both lines low or both lines high). `clear` marks the start of a packet. It also picks the CRC flavour: the 16-bit CRC for data fields, or the 5-bit CRC for token fields. Because stuffed bits are thrown away, a byte may take more than eight steps. The caller keeps stepping until `z_o` rises.

Top module: `usb_rx_bitstep`

## Requirements
- R1: After reset, `data_o` is 0, `z_o` and `c_o` are 0, `crc_o` is 16'hFFFF, and the remembered line level is 1.
- R2: On a step with `dp != dm`, the line level is `dp`. The decoded bit is 1 when that level equals the remembered level and 0 when it differs. The level is then remembered.
- R3: An accepted bit enters `data_o` at bit 7 while the old contents move one place toward bit 0, so the first bit received ends up in bit 0.
- R4: `z_o` is 1 for exactly the step that accepts the eighth bit since the last clear or the last completed byte. It stays 1 until the next step or clear.
- R5: After six accepted ones in a row, the next decoded bit is dropped: it is not shifted in, not counted toward the byte and not fed to the CRC. The run count then restarts at zero.
- R6: With `crc5_sel` low, each accepted bit b updates the CRC as f = b ^ crc[15]; crc = (crc << 1) ^ (f ? 16'h8005 : 0).
- R7: With `crc5_sel` high, the CRC lives in `crc_o[4:0]` with f = b ^ crc[4]; crc = ({crc[3:0],0}) ^ (f ? 5'h05 : 0). `crc_o[15:5]` reads 0 after an accepted bit.
- R8: A step with `dp == dm` sets `c_o` and clears `z_o`. It leaves `data_o`, the CRC, the counters and the remembered level unchanged.
- R9: `clear` zeroes `data_o`, the bit and run counters, `z_o` and `c_o`. It takes the remembered level from `dp` and presets the CRC to 16'hFFFF, or to 16'h001F when `crc5_sel` is high. It takes priority over `step`.
- R10: In a cycle with neither `step` nor `clear`, no output changes, whatever the line inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Process one sampled bit this cycle |
| clear | input | 1 | Start of packet: reset counters and preset CRC |
| crc5_sel | input | 1 | 1 selects the 5-bit CRC, 0 the 16-bit CRC |
| dp | input | 1 | Sampled D+ level |
| dm | input | 1 | Sampled D- level |
| data_o | output | 8 | Byte being assembled, LSB first |
| z_o | output | 1 | Byte completed on the last step |
| c_o | output | 1 | Single-ended line seen on the last step |
| crc_o | output | 16 | Running CRC (5-bit value in bits 4:0 in CRC5 mode) |

## Verification
The hardest state to reach is the stuffed bit: a run of exactly six accepted ones followed by one more step. That run must also cross a byte boundary or fall right after a single-ended step. Uniform random data almost never produces such runs. The random stream is therefore biased so that three bits in four are ones, which makes six-one runs frequent in both CRC modes. Directed sequences also place a stuffed zero in the middle of a byte and put a single-ended sample between the ones of a run.

// File: rtl/usb_rx_bitstep.sv
module usb_rx_bitstep #(
  parameter int          BYTE_BITS = 8,
  parameter int          STUFF_RUN = 6,
  parameter logic [15:0] POLY16    = 16'h8005,
  parameter logic [4:0]  POLY5     = 5'h05
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 clear,
  input  logic                 crc5_sel,
  input  logic                 dp,
  input  logic                 dm,
  output logic [BYTE_BITS-1:0] data_o,
  output logic                 z_o,
  output logic                 c_o,
  output logic [15:0]          crc_o
);
  localparam int CNT_W = $clog2(BYTE_BITS);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(STUFF_RUN);

  logic                 prev_q;
  logic [RUN_W-1:0]     run_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [BYTE_BITS-1:0] sr_q;
  logic [15:0]          crc_q;
  logic                 z_q, c_q;
  logic [15:0]          crc_n;

  wire se     = (dp == dm);
  wire bit_v  = (dp == prev_q);
  wire drop   = (run_q == RUN_MAX);
  wire active = step && !clear && !se;
  wire take   = active && !drop;

  always_comb begin
    if (crc5_sel)
      crc_n = {11'b0, crc_q[3:0], 1'b0} ^ ((bit_v ^ crc_q[4]) ? {11'b0, POLY5} : 16'h0);
    else
      crc_n = {crc_q[14:0], 1'b0} ^ ((bit_v ^ crc_q[15]) ? POLY16 : 16'h0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      run_q  <= '0;
      cnt_q  <= '0;
      sr_q   <= '0;
      crc_q  <= 16'hFFFF;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
    end else if (clear) begin
      prev_q <= dp;
      run_q  <= '0;
      cnt_q  <= '0;
      sr_q   <= '0;
      crc_q  <= crc5_sel ? 16'h001F : 16'hFFFF;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
    end else if (step) begin
      c_q <= se;
      z_q <= take && (cnt_q == LAST_BIT);
      if (active) begin
        prev_q <= dp;
        if (drop) begin
          run_q <= '0;
        end else begin
          run_q <= bit_v ? run_q + 1'b1 : '0;
          cnt_q <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
          sr_q  <= {bit_v, sr_q[BYTE_BITS-1:1]};
          crc_q <= crc_n;
        end
      end
    end
  end

  assign data_o = sr_q;
  assign z_o    = z_q;
  assign c_o    = c_q;
  assign crc_o  = crc_q;
endmodule

// File: rtl/usb_rx_bitstep_chk.sv
module usb_rx_bitstep_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic        clear,
  input logic        crc5_sel,
  input logic        dp,
  input logic        dm,
  input logic [7:0]  data_o,
  input logic        z_o,
  input logic        c_o,
  input logic [15:0] crc_o,
  input logic [7:0]  run
);
  assert_se_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clear && (dp == dm) |=> c_o && !z_o);
  assert_se_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clear && (dp == dm) |=> $stable(data_o) && $stable(crc_o));
  assert_clear16_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear && !crc5_sel |=> crc_o == 16'hFFFF && !z_o && !c_o && data_o == 8'h00);
  assert_clear5_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear && crc5_sel |=> crc_o == 16'h001F && !z_o && !c_o);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !clear |=> $stable(data_o) && $stable(crc_o) && $stable(z_o) && $stable(c_o));
  assert_run_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 8'd6);
  assert_z_after_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(z_o) |-> $past(step) && !$past(clear));
  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(z_o && c_o));
endmodule

bind usb_rx_bitstep usb_rx_bitstep_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .clear(clear), .crc5_sel(crc5_sel),
  .dp(dp), .dm(dm), .data_o(data_o[7:0]), .z_o(z_o), .c_o(c_o), .crc_o(crc_o),
  .run(8'(run_q))
);

// File: tb/usb_rx_bitstep_test.sv
`timescale 1ns/1ps
module usb_rx_bitstep_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0, clear = 1'b0, crc5_sel = 1'b0, dp = 1'b1, dm = 1'b0;
  logic [7:0]  data_o;
  logic        z_o, c_o;
  logic [15:0] crc_o;

  always #4 clk = ~clk;

  usb_rx_bitstep uut (
    .clk(clk), .rst_n(rst_n), .step(step), .clear(clear), .crc5_sel(crc5_sel),
    .dp(dp), .dm(dm), .data_o(data_o), .z_o(z_o), .c_o(c_o), .crc_o(crc_o)
  );

  int checks = 0, fails = 0;
  logic       m_prev = 1'b1;
  int         m_run = 0, m_cnt = 0;
  logic [7:0] m_sr = 8'h00;
  logic [15:0] m_crc = 16'hFFFF;
  logic       m_z = 1'b0, m_c = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_next(input logic [15:0] c, input logic b, input logic sel);
    logic f;
    if (sel) begin
      f = b ^ c[4];
      return {11'b0, c[3:0], 1'b0} ^ (f ? 16'h0005 : 16'h0000);
    end
    f = b ^ c[15];
    return {c[14:0], 1'b0} ^ (f ? 16'h8005 : 16'h0000);
  endfunction

  task automatic check_all(input logic sel);
    chk("R3 data", {8'h00, data_o}, {8'h00, m_sr});
    chk("R4 z", {15'b0, z_o}, {15'b0, m_z});
    chk("R8 c", {15'b0, c_o}, {15'b0, m_c});
    if (sel) chk("R7 crc5", crc_o, m_crc);
    else     chk("R6 crc16", crc_o, m_crc);
  endtask

  task automatic do_clear(input logic lvl, input logic sel);
    @(negedge clk);
    clear = 1'b1; step = 1'b1; crc5_sel = sel; dp = lvl; dm = ~lvl;
    @(negedge clk);
    clear = 1'b0; step = 1'b0;
    m_prev = lvl; m_run = 0; m_cnt = 0; m_sr = 8'h00;
    m_crc = sel ? 16'h001F : 16'hFFFF; m_z = 1'b0; m_c = 1'b0;
    chk("R9 clear crc", crc_o, m_crc);
    chk("R9 clear data", {8'h00, data_o}, 16'h0000);
  endtask

  task automatic step_line(input logic l_dp, input logic l_dm, input logic sel);
    logic b;
    @(negedge clk);
    step = 1'b1; dp = l_dp; dm = l_dm; crc5_sel = sel;
    @(negedge clk);
    step = 1'b0;
    if (l_dp == l_dm) begin
      m_c = 1'b1; m_z = 1'b0;
    end else begin
      m_c = 1'b0; m_z = 1'b0;
      b = (l_dp == m_prev);
      m_prev = l_dp;
      if (m_run == 6) begin
        m_run = 0;
      end else begin
        m_run = b ? m_run + 1 : 0;
        m_sr  = {b, m_sr[7:1]};
        m_crc = crc_next(m_crc, b, sel);
        m_z   = (m_cnt == 7);
        m_cnt = (m_cnt == 7) ? 0 : m_cnt + 1;
      end
    end
    check_all(sel);
  endtask

  task automatic send_bit(input logic b, input logic sel);
    logic lvl;
    lvl = b ? m_prev : ~m_prev;
    step_line(lvl, ~lvl, sel);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 data", {8'h00, data_o}, 16'h0000);
    chk("R1 z", {15'b0, z_o}, 16'h0000);
    chk("R1 c", {15'b0, c_o}, 16'h0000);
    chk("R1 crc", crc_o, 16'hFFFF);

    // R2 NRZI: unchanged level -> 1, changed -> 0; levels 1,0,0,1,1,0,1,1 after J=1
    do_clear(1'b1, 1'b0);
    step_line(1,0,0); step_line(0,1,0); step_line(0,1,0); step_line(1,0,0);
    step_line(1,0,0); step_line(0,1,0); step_line(1,0,0); step_line(1,0,0);
    chk("R2 decoded byte", {8'h00, data_o}, 16'h0095);
    chk("R4 byte done", {15'b0, z_o}, 16'h0001);

    // R5 stuffed zero dropped mid-byte
    do_clear(1'b1, 1'b0);
    repeat (6) send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    chk("R5 drop keeps data", {8'h00, data_o}, 16'h00FC);
    send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    chk("R5 byte after stuff", {8'h00, data_o}, 16'h00BF);
    chk("R5 z after eight kept", {15'b0, z_o}, 16'h0001);

    // R8 single-ended inside a ones run; both SE0 and SE1
    do_clear(1'b1, 1'b1);
    repeat (3) send_bit(1'b1, 1'b1);
    step_line(0, 0, 1'b1);
    step_line(1, 1, 1'b1);
    repeat (3) send_bit(1'b1, 1'b1);
    send_bit(1'b1, 1'b1);
    chk("R8 run survives SE", m_run, 0);

    // R10 idle with wiggling lines
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d0; logic [15:0] c0; logic z0, cc0;
      d0 = data_o; c0 = crc_o; z0 = z_o; cc0 = c_o;
      @(negedge clk);
      dp = $urandom_range(0, 1); dm = $urandom_range(0, 1); crc5_sel = $urandom_range(0, 1);
      @(negedge clk);
      chk("R10 idle data", {8'h00, data_o}, {8'h00, d0});
      chk("R10 idle crc", crc_o, c0);
      chk("R10 idle flags", {14'b0, z_o, c_o}, {14'b0, z0, cc0});
    end

    // Random stream, ones-biased to force stuffing in both CRC modes
    for (int pk = 0; pk < 40; pk++) begin
      logic sel;
      sel = $urandom_range(0, 1);
      do_clear($urandom_range(0, 1), sel);
      for (int i = 0; i < 60; i++) begin
        if ($urandom_range(0, 19) == 0) begin
          logic s;
          s = $urandom_range(0, 1);
          step_line(s, s, sel);
        end else begin
          send_bit($urandom_range(0, 3) != 0, sel);
        end
      end
    end
    finish_run();
  end
endmodule